// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a byte-addressed non-volatile store on a two-wire serial bus (I2C). It watches open-drain SCL and SDA lines through a two-flop synchronizer on the system clock. It recognises START and STOP conditions and accepts a control byte that selects it by a fixed device code and three board strap inputs. A write command brings a two-byte word address and then data bytes, which collect in a page buffer. The STOP that ends such a command starts a self-timed program cycle. During that cycle the buffered bytes are copied into an on-chip RAM, and the block ignores its own control byte.

Reads come in three forms. A current-address read uses an address counter that keeps its value between transactions. A random read first sends a write command that carries only the address, then a repeated START. A sequential read keeps returning bytes while the host acknowledges them. A write-protect input is sampled only at the STOP that would start programming. There is no clock stretching, so the SCL pull output is never asserted. The array depth, the page size and the program-cycle length are parameters.

Top module: `nvm_i2c_target`

## Requirements
- R1: The target answers only a control byte whose upper seven bits are 1010 followed by `sel_i[2:0]`, most significant bit first. For any other control byte it leaves SDA released on the ninth clock, and it leaves both lines released while idle.
- R2: After a write control byte, two word-address bytes (high byte first) load the address counter. A STOP straight after them updates only the counter and starts no program cycle. A STOP after just the high byte leaves the counter unchanged.
- R3: Each data byte is stored at the counter's page offset, and the offset then increments modulo PAGE_BYTES. The page bits do not change, so bytes past the page end overwrite from the start of the same page.
- R4: A STOP after at least one complete data byte, with `wp_i` low, starts a busy period of PROG_CYCLES clocks, and the buffered bytes reach the array in that period.
- R5: While busy the target does not acknowledge its control byte. Once the period ends it acknowledges again, so the host can poll for completion.
- R6: When `wp_i` is high at that STOP, nothing is written and no busy period starts. Reads are unaffected. The level of `wp_i` during the data bytes has no effect.
- R7: A read control byte with no address phase returns the byte at the address counter, and the counter then advances.
- R8: A write control byte plus word address, then a repeated START and a read control byte, returns data from the loaded address.
- R9: In a read, the counter advances after each byte, wrapping from MEM_DEPTH-1 to 0, for as long as the host acknowledges.
- R10: When the host does not acknowledge a read byte, the target releases SDA and waits for STOP or START.
- R11: A START or STOP at any point aborts the current byte. An incomplete data byte is never written.
- R12: Every byte the target accepts (control, address and data) is acknowledged by pulling SDA low for the whole ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run well above the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level seen on the SCL line |
| sda_i | input | 1 | Level seen on the SDA line |
| scl_pull_o | output | 1 | Pull-low enable for SCL; always 0 (no clock stretching) |
| sda_pull_o | output | 1 | Pull-low enable for SDA (acknowledge and read data) |
| sel_i | input | 3 | Board straps compared with control-byte bits 3..1 |
| wp_i | input | 1 | Write protect, sampled at the STOP that ends a write |

## Verification
The hardest state to reach is the window between a committing STOP and the end of the program cycle. The only way to see it from outside is whether the control byte is acknowledged. The bench therefore probes with a bare write control byte at once after each STOP and expects silence, then keeps polling until an acknowledge returns. It also raises write protect only during the data bytes and drops it before STOP, so that programming must still occur. Other cases build on this: a page overrun that must wrap, a counter that crosses the top of the array, and START or STOP placed in the middle of a byte.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_e;

  typedef enum logic [1:0] {
    BK_CTRL,
    BK_AHI,
    BK_ALO,
    BK_DATA
  } bkind_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/nvm_line_sync.sv
module nvm_line_sync #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prv_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic meta_q, lvl_q, prv_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        lvl_q  <= 1'b1;
        prv_q  <= 1'b1;
      end else begin
        meta_q <= raw_i[g];
        lvl_q  <= meta_q;
        prv_q  <= lvl_q;
      end
    end
    assign lvl_o[g] = lvl_q;
    assign prv_o[g] = prv_q;
  end
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 500000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int TW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic          go_i,
  output logic          busy_o,
  output logic          cm_we_o,
  output logic [PW-1:0] cm_idx_o,
  output logic [7:0]    cm_data_o
);
  // PROG_CYCLES must be at least PAGE_BYTES so the copy finishes in the window.
  logic [7:0]      slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled_q;
  logic [PW:0]     idx_q;
  logic [TW-1:0]   tmr_q;
  logic            busy_q;

  always_ff @(posedge clk) begin
    if (wr_i) slot[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q <= '0;
      idx_q    <= '0;
      tmr_q    <= '0;
      busy_q   <= 1'b0;
    end else begin
      if (clr_i) filled_q <= '0;
      else if (wr_i) filled_q[wr_idx_i] <= 1'b1;

      if (go_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        tmr_q  <= '0;
      end else if (busy_q) begin
        if (!idx_q[PW]) idx_q <= idx_q + (PW+1)'(1);
        if (tmr_q == TW'(PROG_CYCLES - 1)) busy_q <= 1'b0;
        else tmr_q <= tmr_q + TW'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign cm_idx_o  = idx_q[PW-1:0];
  assign cm_data_o = slot[idx_q[PW-1:0]];
  assign cm_we_o   = busy_q && !idx_q[PW] && filled_q[idx_q[PW-1:0]];
endmodule

// File: rtl/nvm_i2c_target.sv
module nvm_i2c_target #(
  parameter int MEM_DEPTH   = 2048,
  parameter int PAGE_BYTES  = 128,
  parameter int PROG_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull_o,
  output logic       sda_pull_o,
  input  logic [2:0] sel_i,
  input  logic       wp_i
);
  import nvm_pkg::*;

  localparam int AW = $clog2(MEM_DEPTH);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [1:0] lvl, prv;
  nvm_line_sync #(.LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({sda_i, scl_i}), .lvl_o(lvl), .prv_o(prv)
  );

  logic scl_s, sda_s, scl_p, sda_p;
  assign scl_s = lvl[0];
  assign sda_s = lvl[1];
  assign scl_p = prv[0];
  assign sda_p = prv[1];

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_s && !scl_p;
  assign scl_fall = !scl_s && scl_p;
  assign start_ev = scl_s && scl_p && sda_p && !sda_s;
  assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;

  phase_e        phase;
  bkind_e        kind;
  logic [3:0]    bit_cnt;
  logic [7:0]    rx_sh, tx_sh, addr_hi, rd_data;
  logic          is_read, addr_ok, data_seen, host_ack;
  logic [AW-1:0] ptr;

  logic          busy, cm_we;
  logic [PW-1:0] cm_idx;
  logic [7:0]    cm_data;

  logic rx_done, dev_hit, data_acc, addr_load, go;
  assign rx_done   = (phase == PH_RX) && scl_fall && (bit_cnt == 4'd8);
  assign dev_hit   = (rx_sh[7:1] == {DEV_CODE, sel_i}) && !busy;
  assign data_acc  = rx_done && (kind == BK_DATA);
  assign addr_load = rx_done && (kind == BK_ALO);
  assign go        = stop_ev && addr_ok && data_seen && !wp_i && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      kind      <= BK_CTRL;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '1;
      addr_hi   <= '0;
      is_read   <= 1'b0;
      addr_ok   <= 1'b0;
      data_seen <= 1'b0;
      host_ack  <= 1'b0;
      ptr       <= '0;
    end else if (start_ev) begin
      phase     <= PH_RX;
      kind      <= BK_CTRL;
      bit_cnt   <= '0;
      is_read   <= 1'b0;
      addr_ok   <= 1'b0;
      data_seen <= 1'b0;
    end else if (stop_ev) begin
      phase     <= PH_IDLE;
      addr_ok   <= 1'b0;
      data_seen <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (rx_done) begin
            bit_cnt <= '0;
            phase   <= PH_RX_ACK;
            unique case (kind)
              BK_CTRL: begin
                if (dev_hit) begin
                  is_read <= rx_sh[0];
                  kind    <= BK_AHI;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              BK_AHI: begin
                addr_hi <= rx_sh;
                kind    <= BK_ALO;
              end
              BK_ALO: begin
                ptr     <= AW'({addr_hi, rx_sh});
                addr_ok <= 1'b1;
                kind    <= BK_DATA;
              end
              default: begin
                ptr       <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                data_seen <= 1'b1;
              end
            endcase
          end
        end
        PH_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read) begin
              phase <= PH_TX;
              tx_sh <= rd_data;
            end else begin
              phase <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            tx_sh   <= {tx_sh[6:0], 1'b1};
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == 4'd7) begin
              phase <= PH_TX_ACK;
              ptr   <= ptr + AW'(1);
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) begin
            host_ack <= !sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (host_ack) begin
              phase <= PH_TX;
              tx_sh <= rd_data;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  nvm_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_page (
    .clk(clk), .rst_n(rst_n),
    .clr_i(addr_load), .wr_i(data_acc), .wr_idx_i(ptr[PW-1:0]), .wr_data_i(rx_sh),
    .go_i(go), .busy_o(busy), .cm_we_o(cm_we), .cm_idx_o(cm_idx), .cm_data_o(cm_data)
  );

  nvm_store #(.DEPTH(MEM_DEPTH)) u_store (
    .clk(clk), .we_i(cm_we), .waddr_i({ptr[AW-1:PW], cm_idx}), .wdata_i(cm_data),
    .raddr_i(ptr), .rdata_o(rd_data)
  );

  assign scl_pull_o = 1'b0;
  assign sda_pull_o = (phase == PH_RX_ACK) || (phase == PH_TX && !tx_sh[7]);

  assert_page_bits_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));
  assert_prog_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
  assert_silent_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);
  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && wp_i && !busy) |=> !busy);
  assert_release_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TX_ACK && scl_fall && !host_ack) |=> !sda_pull_o);
endmodule

// File: tb/nvm_i2c_target_tb.sv
module nvm_i2c_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int DEPTH = 256;
  localparam int PAGE = 8;
  localparam int PROG = 1000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_scl_lo = 1'b0, host_sda_lo = 1'b0, wp = 1'b0;
  logic scl_pull, sda_pull, scl, sda;
  assign scl = !(host_scl_lo || scl_pull);
  assign sda = !(host_sda_lo || sda_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_i2c_target #(.MEM_DEPTH(DEPTH), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .sel_i(STRAP), .wp_i(wp)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] mptr;
  logic [7:0] wbuf [$];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  task automatic qtr; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    host_sda_lo = 0; qtr; host_scl_lo = 0; qtr; host_sda_lo = 1; qtr; host_scl_lo = 1; qtr;
  endtask

  task automatic bus_stop;
    host_scl_lo = 1; host_sda_lo = 1; qtr; host_scl_lo = 0; qtr; host_sda_lo = 0; qtr;
  endtask

  task automatic send_bit(input bit b);
    host_sda_lo = !b; qtr; host_scl_lo = 0; qtr; qtr; host_scl_lo = 1; qtr;
  endtask

  task automatic recv_bit(output bit b);
    host_sda_lo = 0; qtr; host_scl_lo = 0; qtr; b = sda; qtr; host_scl_lo = 1; qtr;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(!give_ack);
  endtask

  task automatic probe(output bit acked);
    bus_start; send_byte(CW, acked); bus_stop;
  endtask

  task automatic wait_ready(input string tag);
    bit a = 0;
    for (int i = 0; i < 20 && !a; i++) probe(a);
    chk(a, tag, a, 1);
  endtask

  // write wbuf at address a; wp level during data and at STOP chosen separately
  task automatic write_page(input logic [7:0] a, input bit wp_mid, input bit wp_end);
    bit ak;
    logic [7:0] base, off;
    bus_start;
    send_byte(CW, ak);   chk(ak, "R12 control ack", ak, 1);
    send_byte(8'h00, ak); chk(ak, "R12 addr-high ack", ak, 1);
    send_byte(a, ak);    chk(ak, "R12 addr-low ack", ak, 1);
    base = a & ~8'(PAGE - 1);
    off  = a & 8'(PAGE - 1);
    wp = wp_mid;
    foreach (wbuf[i]) begin
      send_byte(wbuf[i], ak);
      chk(ak, "R12 data ack", ak, 1);
      if (!wp_end) model[base | off] = wbuf[i];
      off = (off + 8'd1) & 8'(PAGE - 1);
    end
    mptr = base | off;
    wp = wp_end;
    bus_stop;
    wp = 0;
    wbuf.delete();
  endtask

  task automatic read_out(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[mptr]); tag_q.push_back(tag);
      mptr = mptr + 8'd1;
      recv_byte(i != n - 1, d);
      got_q.push_back(d);
    end
  endtask

  task automatic read_random(input logic [7:0] a, input int n, input string tag);
    bit ak;
    bus_start;
    send_byte(CW, ak); send_byte(8'h00, ak); send_byte(a, ak);
    mptr = a;
    bus_start;
    send_byte(CR, ak); chk(ak, "R8 read control ack", ak, 1);
    read_out(n, tag);
    chk(!sda_pull, "R10 SDA released after host NACK", sda_pull, 0);
    bus_stop;
  endtask

  task automatic read_current(input int n, input string tag);
    bit ak;
    bus_start;
    send_byte(CR, ak); chk(ak, "R7 read control ack", ak, 1);
    read_out(n, tag);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ak;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!sda_pull && !scl_pull, "R1 lines released after reset", {scl_pull, sda_pull}, 0);

    // R1: strap mismatch and code mismatch are ignored, a match is answered
    bus_start; send_byte({4'b1010, 3'b100, 1'b0}, ak); bus_stop;
    chk(!ak, "R1 strap mismatch not acked", ak, 0);
    bus_start; send_byte({4'b0010, STRAP, 1'b0}, ak); bus_stop;
    chk(!ak, "R1 device code mismatch not acked", ak, 0);
    probe(ak);
    chk(ak, "R1 matching control acked", ak, 1);

    // R4/R5: page write, then busy polling
    wbuf = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    write_page(8'h10, 0, 0);
    probe(ak);
    chk(!ak, "R4 R5 control NACKed right after STOP", ak, 0);
    wait_ready("R5 ack returns after program cycle");

    read_random(8'h10, 4, "R8 R4 random sequential read");
    read_current(1, "R7 current-address read");

    // R3: wrap inside the page
    wbuf = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6};
    write_page(8'h23, 0, 0);
    wait_ready("R4 ready after wrap write");
    read_random(8'h20, 2, "R3 wrapped bytes at page start");
    read_random(8'h23, 5, "R3 bytes before page end");
    wbuf = '{8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5, 8'hB6, 8'hB7, 8'hB8, 8'hB9};
    write_page(8'h40, 0, 0);
    wait_ready("R4 ready after overrun write");
    read_random(8'h40, 8, "R3 overrun overwrites page start");

    // R6: protected at STOP
    wbuf = '{8'hEE};
    write_page(8'h10, 1, 1);
    probe(ak);
    chk(ak, "R6 no busy period when protected", ak, 1);
    read_random(8'h10, 1, "R6 protected byte unchanged");
    wbuf = '{8'h77};
    write_page(8'h11, 1, 0);
    probe(ak);
    chk(!ak, "R6 protect during data only still programs", ak, 0);
    wait_ready("R6 ready after program");
    read_random(8'h11, 1, "R6 byte written when unprotected at STOP");

    // R2: address-only write and partial address
    wbuf = '{8'hC0, 8'hC1};
    write_page(8'h30, 0, 0);
    wait_ready("R4 ready");
    write_page(8'h30, 0, 0);
    probe(ak);
    chk(ak, "R2 address-only write starts no program", ak, 1);
    read_current(1, "R2 counter loaded by address-only write");
    bus_start; send_byte(CW, ak); send_byte(8'h00, ak); bus_stop;
    read_current(1, "R2 partial address leaves counter");

    // R9: wrap from last location to zero
    wbuf = '{8'hD0, 8'hD1};
    write_page(8'hFE, 0, 0);
    wait_ready("R4 ready");
    wbuf = '{8'hD2};
    write_page(8'h00, 0, 0);
    wait_ready("R4 ready");
    read_random(8'hFE, 3, "R9 sequential read wraps to 0");

    // R11: START mid-byte, then STOP mid data byte
    bus_start;
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    read_random(8'h10, 1, "R11 recovery after START mid-byte");
    bus_start;
    send_byte(CW, ak); send_byte(8'h00, ak); send_byte(8'h40, ak);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_stop;
    probe(ak);
    chk(ak, "R11 partial data byte starts no program", ak, 1);
    read_random(8'h40, 1, "R11 partial data byte not written");

    repeat (20) @(negedge clk);
    chk(got_q.size() == 0 && exp_q.size() == 0, "R8 scoreboard drained",
        got_q.size(), exp_q.size());
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule